// File: doc/BRIEF.md
# Shifter Operand Unit

This block forms the second operand of a data-processing operation together with the carry that the shift produces. It accepts three operand forms. A register value can be shifted by a small constant carried in the instruction. It can be shifted by an amount held in the low byte of another register. Or a short constant can be zero-extended and rotated right by an even amount. The caller supplies the register value, the amount fields and the current carry flag. The block returns the operand and the shifter carry one clock later.

Several amount encodings have special meanings, and they are all handled inside the block. A zero constant amount means a full-width right shift, or a one-bit rotate through the carry. Register-held amounts saturate at different points for logical and arithmetic shifts. A register-held rotate amount that is a nonzero multiple of the width leaves the value unchanged. Register fetch, any program-counter correction and the ALU itself belong to the surrounding datapath.

Top module: `shifter_operand_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state of `operand_o` and `carry_o` is 0, whatever the inputs are.
- R2: The result is registered and appears on the rising edge after the inputs are applied. Form codes are 0 for constant-amount shift, 1 for register-amount shift, and 2 or 3 for rotated constant. Shift type codes are 0 logical left, 1 logical right, 2 arithmetic right and 3 rotate right.
- R3: In the constant-amount form, a logical left shift by 0 passes the value through unchanged, and the carry equals `c_flag_i`.
- R4: In the constant-amount form, a shift by 1 to 31 gives the shifted value. The carry is the last bit shifted out, and a right rotate sets the carry to bit 31 of the result.
- R5: In the constant-amount form, an amount of 0 with logical right means a shift by 32: the result is 0 and the carry is bit 31. With arithmetic right it also means a shift by 32: every bit and the carry equal bit 31.
- R6: In the constant-amount form, rotate right with amount 0 rotates right by one through the carry. `c_flag_i` enters bit 31, and value bit 0 becomes the carry.
- R7: In the register-amount form, only `amt_reg_i` (8 bits) sets the amount. An amount of 0 leaves the value and `c_flag_i` unchanged for every shift type.
- R8: In the register-amount form, a logical shift by exactly 32 gives 0. The carry is value bit 0 for a left shift and value bit 31 for a right shift.
- R9: In the register-amount form, a logical shift by 33 or more gives 0 with carry 0.
- R10: In the register-amount form, an arithmetic right shift by 32 or more fills every bit with bit 31, and the carry equals bit 31.
- R11: In the register-amount form, a nonzero rotate uses the low five bits of the amount. If those bits are zero, the value is unchanged and the carry is bit 31. In every nonzero case the carry is bit 31 of the result.
- R12: In the rotated-constant form, `imm_byte_i` is zero-extended and rotated right by twice `rot_field_i`, and `shift_type_i` is ignored. With a zero rotate field the carry is `c_flag_i`; otherwise the carry is bit 31 of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| form_i | input | 2 | Operand form select |
| shift_type_i | input | 2 | Shift type |
| value_i | input | 32 | Register value to be shifted |
| imm_amt_i | input | 5 | Constant shift amount |
| amt_reg_i | input | 8 | Low byte of the amount register |
| rot_field_i | input | 4 | Half rotate amount for the constant form |
| imm_byte_i | input | 8 | Constant operand byte |
| c_flag_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Every result, including the carry, is due exactly one rising edge after its inputs are driven. Nothing in the block takes longer or shorter. The driver applies each stimulus at a falling edge and queues the expected pair at the same moment. The monitor pops that pair one nanosecond after the next rising edge, so each comparison lines up with the single register stage. The expected values come from a bit-at-a-time shift model, so saturation and the special amount meanings arise from the requirements rather than from the design's decoding.

// File: rtl/shop_pkg.sv
package shop_pkg;

   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shift_kind_e;

   typedef enum logic [1:0] {
      OPF_IMM_SHIFT = 2'd0,
      OPF_REG_SHIFT = 2'd1,
      OPF_ROT_IMM   = 2'd2,
      OPF_ROT_IMM_B = 2'd3
   } opform_e;

   function automatic logic is_rot_form(input logic [1:0] f);
      return f[1];
   endfunction

endpackage

// File: rtl/shop_amount_decode.sv
module shop_amount_decode
   import shop_pkg::*;
#(
   parameter int W         = 32,
   parameter int IMM_AMT_W = 5,
   parameter int REG_AMT_W = 8,
   parameter int ROT_W     = 4,
   parameter int AW        = 6
) (
   input  logic [1:0]           form_i,
   input  shift_kind_e          kind_i,
   input  logic [IMM_AMT_W-1:0] imm_amt_i,
   input  logic [REG_AMT_W-1:0] reg_amt_i,
   input  logic [ROT_W-1:0]     rot_field_i,
   output shift_kind_e          kind_o,
   output logic [AW-1:0]        amt_o,
   output logic                 rrx_o
);

   localparam int LOG_W = $clog2(W);
   localparam logic [REG_AMT_W-1:0] LOGIC_SAT = REG_AMT_W'(W + 1);
   localparam logic [REG_AMT_W-1:0] ARITH_SAT = REG_AMT_W'(W);
   localparam logic [AW-1:0]        FULL_AMT  = AW'(W);

   if (IMM_AMT_W != LOG_W) begin : g_bad_imm_w
      $error("shop_amount_decode: IMM_AMT_W must equal log2(W)");
   end
   if (REG_AMT_W < AW) begin : g_bad_reg_w
      $error("shop_amount_decode: REG_AMT_W too narrow");
   end
   if (2 * ((1 << ROT_W) - 1) >= W) begin : g_bad_rot_w
      $error("shop_amount_decode: rotate field exceeds width");
   end

   always_comb begin
      kind_o = kind_i;
      rrx_o  = 1'b0;
      amt_o  = '0;
      if (is_rot_form(form_i)) begin
         kind_o = SH_ROR;
         amt_o  = AW'({rot_field_i, 1'b0});
      end else if (form_i == OPF_IMM_SHIFT) begin
         amt_o = AW'(imm_amt_i);
         if (imm_amt_i == '0) begin
            case (kind_i)
               SH_LSR, SH_ASR: amt_o = FULL_AMT;
               SH_ROR:         rrx_o = 1'b1;
               default:        amt_o = '0;
            endcase
         end
      end else begin
         case (kind_i)
            SH_LSL, SH_LSR: begin
               if (reg_amt_i > LOGIC_SAT) amt_o = AW'(LOGIC_SAT);
               else                       amt_o = AW'(reg_amt_i);
            end
            SH_ASR: begin
               if (reg_amt_i > ARITH_SAT) amt_o = AW'(ARITH_SAT);
               else                       amt_o = AW'(reg_amt_i);
            end
            default: begin
               if (reg_amt_i == '0)                 amt_o = '0;
               else if (reg_amt_i[LOG_W-1:0] == '0) amt_o = FULL_AMT;
               else                                 amt_o = AW'(reg_amt_i[LOG_W-1:0]);
            end
         endcase
      end
   end

endmodule

// File: rtl/shop_imm_expand.sv
module shop_imm_expand #(
   parameter int W     = 32,
   parameter int IMM_W = 8
) (
   input  logic [IMM_W-1:0] imm_i,
   output logic [W-1:0]     wide_o
);

   if (IMM_W >= W || IMM_W < 1) begin : g_bad_imm
      $error("shop_imm_expand: IMM_W must be between 1 and W-1");
   end

   assign wide_o = {{(W - IMM_W){1'b0}}, imm_i};

endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
   import shop_pkg::*;
#(
   parameter int W             = 32,
   parameter int AW            = 6,
   parameter bit STAGED_ROTATE = 1'b0
) (
   input  logic [W-1:0]  value_i,
   input  shift_kind_e   kind_i,
   input  logic [AW-1:0] amt_i,
   input  logic          rrx_i,
   input  logic          c_in_i,
   output logic [W-1:0]  result_o,
   output logic          c_out_o
);

   localparam int LOG_W = $clog2(W);
   localparam logic [LOG_W:0] W_L = (LOG_W + 1)'(W);

   if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("shop_barrel: W must be a power of two of at least 8");
   end
   if (AW < $clog2(W + 2)) begin : g_bad_aw
      $error("shop_barrel: AW cannot hold W+1");
   end

   logic [W:0]        lsl_w;
   logic [W:0]        lsr_w;
   logic signed [W:0] asr_src;
   logic [W:0]        asr_w;
   logic [LOG_W-1:0]  rot_n;
   logic [W-1:0]      ror_res;

   // carry rides in the extra bit of each widened shift
   assign lsl_w   = {1'b0, value_i} << amt_i;
   assign lsr_w   = {value_i, 1'b0} >> amt_i;
   assign asr_src = {value_i, 1'b0};
   assign asr_w   = asr_src >>> amt_i;
   assign rot_n   = amt_i[LOG_W-1:0];

   if (STAGED_ROTATE) begin : g_rot_staged
      logic [W-1:0] stg [0:LOG_W];
      assign stg[0] = value_i;
      for (genvar s = 0; s < LOG_W; s++) begin : g_stage
         localparam int SH = 1 << s;
         assign stg[s+1] = rot_n[s] ? {stg[s][SH-1:0], stg[s][W-1:SH]} : stg[s];
      end
      assign ror_res = stg[LOG_W];
   end else begin : g_rot_flat
      assign ror_res = (value_i >> rot_n) | (value_i << (W_L - {1'b0, rot_n}));
   end

   always_comb begin
      result_o = value_i;
      c_out_o  = c_in_i;
      if (rrx_i) begin
         result_o = {c_in_i, value_i[W-1:1]};
         c_out_o  = value_i[0];
      end else if (amt_i != '0) begin
         case (kind_i)
            SH_LSL:  {c_out_o, result_o} = lsl_w;
            SH_LSR:  {result_o, c_out_o} = lsr_w;
            SH_ASR:  {result_o, c_out_o} = asr_w;
            default: begin
               result_o = ror_res;
               c_out_o  = ror_res[W-1];
            end
         endcase
      end
   end

endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
   import shop_pkg::*;
#(
   parameter int W             = 32,
   parameter int IMM_AMT_W     = 5,
   parameter int REG_AMT_W     = 8,
   parameter int ROT_W         = 4,
   parameter int IMM_W         = 8,
   parameter bit STAGED_ROTATE = 1'b0,
   parameter bit OUT_REG       = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           form_i,
   input  logic [1:0]           shift_type_i,
   input  logic [W-1:0]         value_i,
   input  logic [IMM_AMT_W-1:0] imm_amt_i,
   input  logic [REG_AMT_W-1:0] amt_reg_i,
   input  logic [ROT_W-1:0]     rot_field_i,
   input  logic [IMM_W-1:0]     imm_byte_i,
   input  logic                 c_flag_i,
   output logic [W-1:0]         operand_o,
   output logic                 carry_o
);

   localparam int AW = $clog2(W + 2);

   shift_kind_e  dec_kind;
   logic [AW-1:0] dec_amt;
   logic          dec_rrx;
   logic [W-1:0]  imm_wide;
   logic [W-1:0]  src_val;
   logic [W-1:0]  sh_res;
   logic          sh_c;

   shop_amount_decode #(
      .W(W), .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W), .ROT_W(ROT_W), .AW(AW)
   ) i_decode (
      .form_i      (form_i),
      .kind_i      (shift_kind_e'(shift_type_i)),
      .imm_amt_i   (imm_amt_i),
      .reg_amt_i   (amt_reg_i),
      .rot_field_i (rot_field_i),
      .kind_o      (dec_kind),
      .amt_o       (dec_amt),
      .rrx_o       (dec_rrx)
   );

   shop_imm_expand #(.W(W), .IMM_W(IMM_W)) i_expand (
      .imm_i  (imm_byte_i),
      .wide_o (imm_wide)
   );

   assign src_val = is_rot_form(form_i) ? imm_wide : value_i;

   shop_barrel #(.W(W), .AW(AW), .STAGED_ROTATE(STAGED_ROTATE)) i_barrel (
      .value_i  (src_val),
      .kind_i   (dec_kind),
      .amt_i    (dec_amt),
      .rrx_i    (dec_rrx),
      .c_in_i   (c_flag_i),
      .result_o (sh_res),
      .c_out_o  (sh_c)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            operand_o <= '0;
            carry_o   <= 1'b0;
         end else begin
            operand_o <= sh_res;
            carry_o   <= sh_c;
         end
      end

      AST_LSL_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n) // R3
         (form_i == OPF_IMM_SHIFT && shift_type_i == SH_LSL && imm_amt_i == '0)
         |=> (operand_o == $past(value_i) && carry_o == $past(c_flag_i)));

      AST_RIGHT_FULL: assert property (@(posedge clk) disable iff (!rst_n) // R5
         (form_i == OPF_IMM_SHIFT && shift_type_i == SH_LSR && imm_amt_i == '0)
         |=> (operand_o == '0 && carry_o == $past(value_i[W-1])));

      AST_RRX_STEP: assert property (@(posedge clk) disable iff (!rst_n) // R6
         (form_i == OPF_IMM_SHIFT && shift_type_i == SH_ROR && imm_amt_i == '0)
         |=> (operand_o[W-1] == $past(c_flag_i) && carry_o == $past(value_i[0])));

      AST_REG_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R7
         (form_i == OPF_REG_SHIFT && amt_reg_i == '0)
         |=> (operand_o == $past(value_i) && carry_o == $past(c_flag_i)));

      AST_LOGIC_OVER: assert property (@(posedge clk) disable iff (!rst_n) // R9
         (form_i == OPF_REG_SHIFT && !shift_type_i[1] && amt_reg_i > REG_AMT_W'(W))
         |=> (operand_o == '0 && !carry_o));

      AST_ROT_CARRY: assert property (@(posedge clk) disable iff (!rst_n) // R12
         (form_i[1] && rot_field_i != '0) |=> (carry_o == operand_o[W-1]));
   end else begin : g_out_comb
      assign operand_o = sh_res;
      assign carry_o   = sh_c;
   end

endmodule

// File: tb/test_shifter_operand_unit.sv
`timescale 1ns/1ps
module test_shifter_operand_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  form_i = '0;
   logic [1:0]  shift_type_i = '0;
   logic [31:0] value_i = '0;
   logic [4:0]  imm_amt_i = '0;
   logic [7:0]  amt_reg_i = '0;
   logic [3:0]  rot_field_i = '0;
   logic [7:0]  imm_byte_i = '0;
   logic        c_flag_i = 1'b0;
   logic [31:0] operand_o;
   logic        carry_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [32:0] q_exp[$];
   string       q_tag[$];

   always #4 clk = ~clk;

   shifter_operand_unit i_shifter_operand_unit (
      .clk(clk), .rst_n(rst_n), .form_i(form_i), .shift_type_i(shift_type_i),
      .value_i(value_i), .imm_amt_i(imm_amt_i), .amt_reg_i(amt_reg_i),
      .rot_field_i(rot_field_i), .imm_byte_i(imm_byte_i), .c_flag_i(c_flag_i),
      .operand_o(operand_o), .carry_o(carry_o)
   );

   // bit-at-a-time model: returns {carry, operand}
   function automatic logic [32:0] model(input logic [1:0] f, input logic [1:0] k,
         input logic [31:0] val, input logic [4:0] i5, input logic [7:0] rb,
         input logic [3:0] rt, input logic [7:0] i8, input logic c);
      logic [31:0] v = val;
      logic        cy = c;
      int          n = 0;
      logic [1:0]  kk = k;
      if (f[1]) begin
         v  = {24'd0, i8};
         kk = 2'd3;
         n  = 2 * rt;
      end else if (f == 2'd0) begin
         n = i5;
         if (i5 == 0 && (k == 2'd1 || k == 2'd2)) n = 32;
         if (i5 == 0 && k == 2'd3) return {val[0], c, val[31:1]};
      end else begin
         n = rb;
      end
      for (int i = 0; i < n; i++) begin
         case (kk)
            2'd0: begin cy = v[31]; v = v << 1; end
            2'd1: begin cy = v[0];  v = v >> 1; end
            2'd2: begin cy = v[0];  v = {v[31], v[31:1]}; end
            default: begin cy = v[0]; v = {v[0], v[31:1]}; end
         endcase
      end
      return {cy, v};
   endfunction

   task automatic drive(input logic [1:0] f, input logic [1:0] k, input logic [31:0] val,
         input logic [4:0] i5, input logic [7:0] rb, input logic [3:0] rt,
         input logic [7:0] i8, input logic c, input string tag);
      @(negedge clk);
      form_i = f; shift_type_i = k; value_i = val; imm_amt_i = i5;
      amt_reg_i = rb; rot_field_i = rt; imm_byte_i = i8; c_flag_i = c;
      q_exp.push_back(model(f, k, val, i5, rb, rt, i8, c));
      q_tag.push_back(tag);
   endtask

   task automatic expect_direct(input logic [32:0] exp, input logic [32:0] got, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual op=%h c=%b expected op=%h c=%b",
                  tag, got[31:0], got[32], exp[31:0], exp[32]);
      end
   endtask

   // monitor: result of inputs driven at a falling edge is due after the next rising edge
   always @(posedge clk) begin
      #1;
      if (q_exp.size() != 0) begin
         logic [32:0] e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         expect_direct(e, {carry_o, operand_o}, t);
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset holds outputs at zero despite active inputs
      value_i = 32'hDEAD_BEEF; c_flag_i = 1'b1; form_i = 2'd1; amt_reg_i = 8'd4;
      repeat (3) @(posedge clk);
      @(negedge clk);
      expect_direct(33'd0, {carry_o, operand_o}, "R1 reset state");
      rst_n = 1'b1;

      // R3
      drive(2'd0, 2'd0, 32'h8000_0001, 5'd0, 8'd0, 4'd0, 8'd0, 1'b1, "R3 lsl0 c1");
      drive(2'd0, 2'd0, 32'h1234_5678, 5'd0, 8'd0, 4'd0, 8'd0, 1'b0, "R3 lsl0 c0");
      // R4
      drive(2'd0, 2'd0, 32'hC000_0003, 5'd1, 8'd0, 4'd0, 8'd0, 1'b0, "R4 lsl1");
      drive(2'd0, 2'd1, 32'h0000_00F0, 5'd5, 8'd0, 4'd0, 8'd0, 1'b0, "R4 lsr5");
      drive(2'd0, 2'd2, 32'h8000_0010, 5'd31, 8'd0, 4'd0, 8'd0, 1'b0, "R4 asr31");
      drive(2'd0, 2'd3, 32'h0000_0001, 5'd1, 8'd0, 4'd0, 8'd0, 1'b0, "R4 ror1");
      // R5
      drive(2'd0, 2'd1, 32'h8000_0000, 5'd0, 8'd0, 4'd0, 8'd0, 1'b0, "R5 lsr imm0");
      drive(2'd0, 2'd2, 32'h8765_4321, 5'd0, 8'd0, 4'd0, 8'd0, 1'b0, "R5 asr imm0 neg");
      drive(2'd0, 2'd2, 32'h7FFF_FFFF, 5'd0, 8'd0, 4'd0, 8'd0, 1'b1, "R5 asr imm0 pos");
      // R6
      drive(2'd0, 2'd3, 32'h0000_0003, 5'd0, 8'd0, 4'd0, 8'd0, 1'b1, "R6 rrx c1");
      drive(2'd0, 2'd3, 32'hFFFF_FFFE, 5'd0, 8'd0, 4'd0, 8'd0, 1'b0, "R6 rrx c0");
      // R7
      for (int k = 0; k < 4; k++) begin
         drive(2'd1, 2'(k), 32'hA5A5_0F0F, 5'd7, 8'd0, 4'd0, 8'd0, 1'b1, "R7 reg amount zero");
      end
      drive(2'd1, 2'd0, 32'h0000_0001, 5'd0, 8'd8, 4'd0, 8'd0, 1'b1, "R7 low byte amount 8");
      // R8
      drive(2'd1, 2'd0, 32'h0000_0001, 5'd0, 8'd32, 4'd0, 8'd0, 1'b0, "R8 lsl32");
      drive(2'd1, 2'd1, 32'h8000_0000, 5'd0, 8'd32, 4'd0, 8'd0, 1'b0, "R8 lsr32");
      // R9
      drive(2'd1, 2'd0, 32'hFFFF_FFFF, 5'd0, 8'd33, 4'd0, 8'd0, 1'b1, "R9 lsl33");
      drive(2'd1, 2'd1, 32'hFFFF_FFFF, 5'd0, 8'd200, 4'd0, 8'd0, 1'b1, "R9 lsr200");
      // R10
      drive(2'd1, 2'd2, 32'h8000_0000, 5'd0, 8'd32, 4'd0, 8'd0, 1'b0, "R10 asr32");
      drive(2'd1, 2'd2, 32'h4000_0000, 5'd0, 8'd255, 4'd0, 8'd0, 1'b1, "R10 asr255");
      // R11
      drive(2'd1, 2'd3, 32'h8000_1234, 5'd0, 8'd32, 4'd0, 8'd0, 1'b0, "R11 ror32");
      drive(2'd1, 2'd3, 32'h0000_1234, 5'd0, 8'd64, 4'd0, 8'd0, 1'b1, "R11 ror64");
      drive(2'd1, 2'd3, 32'h0000_0010, 5'd0, 8'd37, 4'd0, 8'd0, 1'b0, "R11 ror37");
      // R12
      drive(2'd2, 2'd0, 32'hFFFF_FFFF, 5'd0, 8'd0, 4'd0, 8'hAB, 1'b1, "R12 rot0 c1");
      drive(2'd2, 2'd1, 32'h0, 5'd0, 8'd0, 4'd1, 8'h03, 1'b0, "R12 rot1");
      drive(2'd3, 2'd2, 32'h0, 5'd0, 8'd0, 4'd4, 8'hF0, 1'b0, "R12 form3 rot4");
      drive(2'd2, 2'd3, 32'h0, 5'd0, 8'd0, 4'd15, 8'h81, 1'b1, "R12 rot15");
      // R2: broad mixed stimulus
      for (int i = 0; i < 400; i++) begin
         drive(2'($urandom), 2'($urandom), $urandom, 5'($urandom), 8'($urandom % 70),
               4'($urandom), 8'($urandom), 1'($urandom), "R2 mixed");
      end
      @(posedge clk);
      @(posedge clk);
      #2;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule